// File: doc/BRIEF.md
# Dual-Path Divider Configuration Loader

This block holds the settings a clock synthesizer needs from its control logic: a 9-bit feedback divide value, a 2-bit post-divider select and a 3-bit test-output select. It presents these values to the divider counters as registered, stable outputs. The values can arrive in two ways. A parallel strobe makes the divide inputs pass straight through while it is low and freezes them on its rising edge. A serial clock and data line fill a 14-bit shift register, and the falling edge of a separate serial-load pin then commits the shifted word.

All control pins are treated as slow, independent strobes. The block samples them with the system clock through a synchronizer of `SYNC_STAGES` flops and detects their edges in that clock domain. Serial activity only counts while the parallel strobe is high. The test select is held at zero whenever the parallel strobe is low, so it can only be set through the serial path. The last shift-register stage is brought out, so the whole stream can be read back one bit per serial clock.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst` is high, `m_div`, `n_sel`, `t_sel` and `ser_tail` are zero and `div_ratio` is 1.
- R2: While `par_strobe` is low, `m_div` and `n_sel` follow `m_par` and `n_par`, with `SYNC_STAGES`+1 clock cycles of latency.
- R3: On a rising edge of `par_strobe`, `m_div` and `n_sel` keep the parallel input values present at that edge. Later changes on `m_par` and `n_par` have no effect while the strobe stays high.
- R4: While `par_strobe` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 14-bit shift register. `ser_tail` shows bit 13, the bit shifted in 14 edges earlier.
- R5: A falling edge of `ser_load` while `par_strobe` is high commits the stream. The first three bits sent become `t_sel`, the next two become `n_sel`, and the last nine become `m_div`. Each field is sent MSB first (word bits [13:11], [10:9] and [8:0]).
- R6: While `par_strobe` is low, `ser_clk` edges leave the shift register unchanged and `ser_load` edges commit nothing.
- R7: `t_sel` is 000 whenever `par_strobe` is low. The parallel inputs never set it.
- R8: `div_ratio` decodes `n_sel` as 00=1, 01=2, 10=4, 11=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_strobe | input | 1 | Parallel strobe: transparent when low, captures on its rising edge |
| m_par | input | 9 | Parallel feedback divide value |
| n_par | input | 2 | Parallel post-divider select |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial commit strobe, acts on its falling edge |
| m_div | output | 9 | Committed feedback divide value |
| n_sel | output | 2 | Committed post-divider select |
| t_sel | output | 3 | Committed test-output select |
| div_ratio | output | 4 | Decoded post-divide ratio (1, 2, 4 or 8) |
| ser_tail | output | 1 | Last stage of the shift register |

## Verification
On every cycle the assertions check that the committed registers track the parallel inputs while the strobe is low and hold otherwise. They also check that a serial commit copies the shifted word, that the test select clears, and that the shift register moves by exactly one position only when a qualified serial edge arrives. Only the bench's scenarios can show the end-to-end behaviour at the pins. That covers field order and MSB-first arrival across a full 14-bit stream, capture of the value present at the strobe edge, and serial edges arriving while the strobe is low leaving no trace. It also covers the 14-edge read-back through the tail output.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_BITS      = 9;
  localparam int N_BITS      = 2;
  localparam int T_BITS      = 3;
  localparam int STREAM_BITS = T_BITS + N_BITS + M_BITS;
  localparam int RATIO_BITS  = 1 << N_BITS;

  // Stream layout: first-sent field ends up in the upper bits.
  typedef struct packed {
    logic [T_BITS-1:0] t;
    logic [N_BITS-1:0] n;
    logic [M_BITS-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/divcfg_edge.sv
module divcfg_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         tail
);
  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (en) word <= {word[W-2:0], din};
  end

  assign tail = word[W-1];

  p_shift_in_r4: assert property (@(posedge clk) disable iff (rst)
    en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(word));
endmodule

// File: rtl/divcfg_commit.sv
module divcfg_commit
  import divcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              par_open,
  input  logic              par_cap,
  input  logic              ser_commit,
  input  logic [M_BITS-1:0] m_in,
  input  logic [N_BITS-1:0] n_in,
  input  cfg_word_t         word,
  output logic [M_BITS-1:0] m_q,
  output logic [N_BITS-1:0] n_q,
  output logic [T_BITS-1:0] t_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      n_q <= '0;
      t_q <= '0;
    end else if (par_open || par_cap) begin
      m_q <= m_in;
      n_q <= n_in;
      t_q <= '0;
    end else if (ser_commit) begin
      m_q <= word.m;
      n_q <= word.n;
      t_q <= word.t;
    end
  end

  p_track_r2: assert property (@(posedge clk) disable iff (rst)
    par_open |=> (m_q == $past(m_in)) && (n_q == $past(n_in)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!par_open && !par_cap && !ser_commit) |=>
      ($stable(m_q) && $stable(n_q) && $stable(t_q)));

  p_commit_r5: assert property (@(posedge clk) disable iff (rst)
    (ser_commit && !par_open && !par_cap) |=>
      (m_q == $past(word.m)) && (n_q == $past(word.n)) && (t_q == $past(word.t)));

  p_t_clear_r7: assert property (@(posedge clk) disable iff (rst)
    par_open |=> (t_q == '0));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  par_strobe,
  input  logic [M_BITS-1:0]     m_par,
  input  logic [N_BITS-1:0]     n_par,
  input  logic                  ser_clk,
  input  logic                  ser_data,
  input  logic                  ser_load,
  output logic [M_BITS-1:0]     m_div,
  output logic [N_BITS-1:0]     n_sel,
  output logic [T_BITS-1:0]     t_sel,
  output logic [RATIO_BITS-1:0] div_ratio,
  output logic                  ser_tail
);
  localparam int BUS_W = 4 + M_BITS + N_BITS;

  logic [BUS_W-1:0]  raw_bus, syn_bus;
  logic              pl_s, sc_s, sl_s, sd_s;
  logic [M_BITS-1:0] m_s;
  logic [N_BITS-1:0] n_s;
  logic              pl_rise, pl_fall_unused;
  logic              sc_rise, sc_fall_unused;
  logic              sl_rise_unused, sl_fall;
  logic [STREAM_BITS-1:0] sh_word;
  cfg_word_t         word;

  assign raw_bus = {par_strobe, ser_clk, ser_load, ser_data, m_par, n_par};

  divcfg_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign {pl_s, sc_s, sl_s, sd_s, m_s, n_s} = syn_bus;

  divcfg_edge u_pl_edge (.clk(clk), .rst(rst), .lvl(pl_s),
                         .rise(pl_rise), .fall(pl_fall_unused));
  divcfg_edge u_sc_edge (.clk(clk), .rst(rst), .lvl(sc_s),
                         .rise(sc_rise), .fall(sc_fall_unused));
  divcfg_edge u_sl_edge (.clk(clk), .rst(rst), .lvl(sl_s),
                         .rise(sl_rise_unused), .fall(sl_fall));

  divcfg_shift #(.W(STREAM_BITS)) u_shift (
    .clk(clk), .rst(rst), .en(pl_s & sc_rise), .din(sd_s),
    .word(sh_word), .tail(ser_tail)
  );

  assign word = cfg_word_t'(sh_word);

  divcfg_commit u_commit (
    .clk(clk), .rst(rst),
    .par_open(~pl_s), .par_cap(pl_rise), .ser_commit(pl_s & sl_fall),
    .m_in(m_s), .n_in(n_s), .word(word),
    .m_q(m_div), .n_q(n_sel), .t_q(t_sel)
  );

  assign div_ratio = RATIO_BITS'(1) << n_sel;

  p_ratio_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(div_ratio) == 1);
endmodule

// File: tb/divcfg_loader_test.sv
module divcfg_loader_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_strobe = 1'b0;
  logic [8:0] m_par = '0;
  logic [1:0] n_par = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_load = 1'b0;
  logic [8:0] m_div;
  logic [1:0] n_sel;
  logic [2:0] t_sel;
  logic [3:0] div_ratio;
  logic       ser_tail;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [13:0] model = '0;

  always #10 clk = ~clk;

  divcfg_loader uut (
    .clk(clk), .rst(rst), .par_strobe(par_strobe), .m_par(m_par), .n_par(n_par),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_div(m_div), .n_sel(n_sel), .t_sel(t_sel), .div_ratio(div_ratio),
    .ser_tail(ser_tail)
  );

  function automatic int ratio_of(input logic [1:0] n);
    return 1 << n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b, input bit active, input string req);
    ser_data = b;
    step();
    ser_clk = 1'b1;
    step();
    ser_clk = 1'b0;
    step();
    if (active) model = {model[12:0], b};
    chk(req, ser_tail, model[13]);
  endtask

  task automatic send_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) shift_bit(w[i], 1'b1, "R4 tail");
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    step();
    ser_load = 1'b0;
    step();
  endtask

  task automatic check_committed(input string req);
    chk({req, " t"}, t_sel, model[13:11]);
    chk({req, " n"}, n_sel, model[10:9]);
    chk({req, " m"}, m_div, model[8:0]);
    chk("R8 ratio", div_ratio, ratio_of(model[10:9]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] mv, mold;
    logic [1:0] nv, nold;
    logic [13:0] w;
    void'($urandom(32'd4242));
    m_par = 9'h1A5;
    n_par = 2'b11;
    repeat (8) @(negedge clk);
    // R1: reset state
    chk("R1 m", m_div, 0);
    chk("R1 n", n_sel, 0);
    chk("R1 t", t_sel, 0);
    chk("R1 tail", ser_tail, 0);
    chk("R1 ratio", div_ratio, 1);
    rst = 1'b0;
    step();

    // R2, R8: every N code through the parallel path
    for (int k = 0; k < 4; k++) begin
      m_par = 9'($urandom);
      n_par = 2'(k);
      step();
      chk("R2 m", m_div, m_par);
      chk("R2 n", n_sel, n_par);
      chk("R8 ratio", div_ratio, ratio_of(2'(k)));
      chk("R7 t", t_sel, 0);
    end

    // directed streams: all ones, then alternating
    par_strobe = 1'b1;
    step();
    send_word(14'h3FFF);
    pulse_load();
    check_committed("R5 ones");
    send_word(14'h2AAA);
    pulse_load();
    check_committed("R5 alt");

    for (int r = 0; r < 12; r++) begin
      par_strobe = 1'b0;
      mv = 9'($urandom);
      nv = 2'($urandom);
      m_par = mv;
      n_par = nv;
      step();
      chk("R2 m", m_div, mv);
      chk("R2 n", n_sel, nv);
      chk("R7 t", t_sel, 0);

      par_strobe = 1'b1;
      step();
      mold = mv;
      nold = nv;
      m_par = ~mv;
      n_par = ~nv;
      step();
      chk("R3 m", m_div, mold);
      chk("R3 n", n_sel, nold);

      w = 14'($urandom);
      send_word(w);
      chk("R4 word", model, w);
      pulse_load();
      check_committed("R5");

      if (r % 2 == 1) begin
        // R7: dropping the strobe clears T
        par_strobe = 1'b0;
        step();
        chk("R7 t", t_sel, 0);
        chk("R2 m", m_div, m_par);
        // R6: serial activity ignored while strobe low
        for (int j = 0; j < 3; j++) shift_bit(1'($urandom), 1'b0, "R6 tail");
        pulse_load();
        chk("R6 t", t_sel, 0);
        chk("R6 m", m_div, m_par);
        par_strobe = 1'b1;
        step();
        pulse_load();
        check_committed("R6 recommit");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule